// File: doc/BRIEF.md
# Burst Read Ready Generator

This block produces the ready/wait indication for the read port of a synchronous memory that delivers data in linear bursts. The host pulses a start strobe together with a starting word address and then keeps an active/advance input high for as long as it wants the burst to continue. The block counts through the word addresses of the burst. It pulls `rdy` low whenever the host has to wait: first for a fixed latency after the burst is started, and again each time the burst steps across the end of an aligned group of 64 words.

A configuration input sets the length of each wait at a group boundary. When it is clear, each boundary wait lasts one clock. When it is set, each boundary wait lasts two clocks. The setting is sampled in the cycle in which the last word of the group is transferred. While no burst is in progress, `rdy` stays high and the other inputs have no effect. The memory array, command decoding and asynchronous reads belong to other blocks.

Top module: `brrg_ready_gen`

## Requirements
- R1: A synchronous active-high reset puts the block in the idle state, and `rdy` is 1 in the first cycle after the reset edge.
- R2: While idle, `rdy` stays 1 whatever `start_addr`, `burst_adv` and `wait2_cfg` do, until `burst_start` is seen high at a clock edge.
- R3: After a clock edge with `burst_start` = 1, `rdy` is 0 for exactly `LAT_CYC` cycles (default 4) and then 1, provided `burst_adv` is held at 1.
- R4: Each cycle in which `rdy` = 1, the burst is active and `burst_adv` = 1, one word is transferred and the word address advances by one. The address does not move while `rdy` = 0.
- R5: A group boundary is a transfer at an address whose low 6 bits are all ones (first at 3Fh). After such a transfer with `wait2_cfg` = 0, `rdy` is 0 for exactly one cycle.
- R6: After a boundary transfer with `wait2_cfg` = 1, `rdy` is 0 for exactly two cycles.
- R7: Boundaries recur every 64 words within one burst, and each boundary applies the wait length selected at that boundary.
- R8: A `burst_start` during a burst in progress, including during the latency or a boundary wait, aborts that burst, loads the new address and restarts the full latency.
- R9: A clock edge with `burst_active` low (`burst_adv` = 0) and no `burst_start` ends the burst, and `rdy` is 1 from the next cycle on.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| burst_start | input | 1 | Start strobe; loads `start_addr` and begins the latency |
| start_addr | input | ADDR_W | First word address of the burst |
| burst_adv | input | 1 | Burst active/advance; low ends the burst |
| wait2_cfg | input | 1 | 0: one-cycle boundary wait, 1: two-cycle boundary wait |
| rdy | output | 1 | 1: data word valid / host may proceed; 0: host waits |

## Verification
The bench aims at the off-by-one edges. It starts bursts a few words below a 3Fh boundary, so a design that puts the wait before the boundary word, or one cycle too late, shifts every later `rdy` edge. It crosses two boundaries in one burst with different wait settings, which catches a wait length latched once per burst instead of at each boundary. It starts new bursts and drops the active input inside the latency and inside boundary waits; a design that ignores the abort, or keeps counting from the old address, shows a wrong low-time or a misplaced boundary.

// File: rtl/brrg_pkg.sv
package brrg_pkg;

    // Burst phases tracked by the controller
    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_LAT  = 2'd1,
        PH_RUN  = 2'd2,
        PH_GAP  = 2'd3
    } phase_e;

    // Per-cycle commands from the phase controller to the datapath
    typedef struct packed {
        logic lat_load;   // restart the initial latency count
        logic gap_load;   // start a boundary wait
        logic gap_two;    // boundary wait lasts two cycles
        logic addr_load;  // take the start address
        logic addr_inc;   // a word is transferred this cycle
    } ctl_t;

    // True when the low grp_w bits of a are all ones
    function automatic logic at_group_end(input logic [31:0] a, input int grp_w);
        logic [31:0] mask;
        mask = (32'd1 << grp_w) - 32'd1;
        return (a & mask) == mask;
    endfunction

    // Ready is high outside a burst and while words flow
    function automatic logic phase_ready(input phase_e ph);
        return (ph == PH_IDLE) || (ph == PH_RUN);
    endfunction

endpackage

// File: rtl/brrg_addr_ctr.sv
module brrg_addr_ctr #(
    parameter int ADDR_W = 22
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [ADDR_W-1:0] load_val,
    input  logic              inc,
    output logic [ADDR_W-1:0] addr
);

    logic [ADDR_W-1:0] addr_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            addr_q <= '0;
        end else if (load) begin
            addr_q <= load_val;
        end else if (inc) begin
            addr_q <= addr_q + ADDR_W'(1);
        end
    end

    assign addr = addr_q;

endmodule

// File: rtl/brrg_wait_timer.sv
module brrg_wait_timer #(
    parameter int LAT_CYC = 4,
    parameter int CNT_W   = 3
) (
    input  logic clk,
    input  logic rst,
    input  logic lat_load,
    input  logic gap_load,
    input  logic gap_two,
    output logic done
);

    localparam logic [CNT_W-1:0] LAT_LAST = CNT_W'(LAT_CYC - 1);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (lat_load) begin
            cnt_q <= LAT_LAST;
        end else if (gap_load) begin
            cnt_q <= gap_two ? CNT_W'(1) : '0;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - CNT_W'(1);
        end
    end

    assign done = (cnt_q == '0);

endmodule

// File: rtl/brrg_phase_fsm.sv
module brrg_phase_fsm
    import brrg_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   start,
    input  logic   adv,
    input  logic   boundary,
    input  logic   tmr_done,
    input  logic   wait2,
    output phase_e phase,
    output ctl_t   ctl
);

    phase_e phase_q;
    phase_e phase_d;

    always_comb begin
        phase_d = phase_q;
        ctl     = '0;
        if (start) begin
            phase_d       = PH_LAT;
            ctl.lat_load  = 1'b1;
            ctl.addr_load = 1'b1;
        end else begin
            unique case (phase_q)
                PH_IDLE: phase_d = PH_IDLE;
                PH_LAT: begin
                    if (!adv)          phase_d = PH_IDLE;
                    else if (tmr_done) phase_d = PH_RUN;
                end
                PH_RUN: begin
                    if (!adv) begin
                        phase_d = PH_IDLE;
                    end else begin
                        ctl.addr_inc = 1'b1;
                        if (boundary) begin
                            phase_d      = PH_GAP;
                            ctl.gap_load = 1'b1;
                            ctl.gap_two  = wait2;
                        end
                    end
                end
                PH_GAP: begin
                    if (!adv)          phase_d = PH_IDLE;
                    else if (tmr_done) phase_d = PH_RUN;
                end
                default: phase_d = PH_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) phase_q <= PH_IDLE;
        else     phase_q <= phase_d;
    end

    assign phase = phase_q;

endmodule

// File: rtl/brrg_ready_gen.sv
module brrg_ready_gen
    import brrg_pkg::*;
#(
    parameter int ADDR_W  = 22,
    parameter int LAT_CYC = 4,
    parameter int GROUP_W = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              burst_start,
    input  logic [ADDR_W-1:0] start_addr,
    input  logic              burst_adv,
    input  logic              wait2_cfg,
    output logic              rdy
);

    localparam int CNT_W = $clog2(LAT_CYC + 2);

    phase_e            phase_q;
    ctl_t              ctl;
    logic [ADDR_W-1:0] word_addr;
    logic              tmr_done;
    logic              grp_end;

    generate
        if (ADDR_W > 32 || GROUP_W < 1 || GROUP_W > ADDR_W || LAT_CYC < 1) begin : g_bad_cfg
            initial $error("brrg_ready_gen: unsupported parameter set");
        end
    endgenerate

    brrg_phase_fsm u_fsm (
        .clk      (clk),
        .rst      (rst),
        .start    (burst_start),
        .adv      (burst_adv),
        .boundary (grp_end),
        .tmr_done (tmr_done),
        .wait2    (wait2_cfg),
        .phase    (phase_q),
        .ctl      (ctl)
    );

    brrg_wait_timer #(
        .LAT_CYC (LAT_CYC),
        .CNT_W   (CNT_W)
    ) u_tmr (
        .clk      (clk),
        .rst      (rst),
        .lat_load (ctl.lat_load),
        .gap_load (ctl.gap_load),
        .gap_two  (ctl.gap_two),
        .done     (tmr_done)
    );

    brrg_addr_ctr #(
        .ADDR_W (ADDR_W)
    ) u_addr (
        .clk      (clk),
        .rst      (rst),
        .load     (ctl.addr_load),
        .load_val (start_addr),
        .inc      (ctl.addr_inc),
        .addr     (word_addr)
    );

    assign grp_end = at_group_end(32'(word_addr), GROUP_W);
    assign rdy     = phase_ready(phase_q);

endmodule

// File: rtl/brrg_ready_gen_chk.sv
module brrg_ready_gen_chk
    import brrg_pkg::*;
#(
    parameter int ADDR_W  = 22,
    parameter int GROUP_W = 6
) (
    input logic              clk,
    input logic              rst,
    input logic              burst_start,
    input logic [ADDR_W-1:0] start_addr,
    input logic              burst_adv,
    input logic              wait2_cfg,
    input logic              rdy,
    input phase_e            phase_q,
    input logic [ADDR_W-1:0] word_addr
);

    logic grp_end;
    logic xfer;
    logic two_gap_q;

    assign grp_end = at_group_end(32'(word_addr), GROUP_W);
    assign xfer    = (phase_q == PH_RUN) && burst_adv && !burst_start;

    always_ff @(posedge clk) begin
        if (rst) two_gap_q <= 1'b0;
        else     two_gap_q <= xfer && grp_end && wait2_cfg;
    end

    // R1
    reset_ready_chk: assert property (@(posedge clk) rst |=> rdy);

    // R2
    idle_ready_chk: assert property (@(posedge clk) disable iff (rst)
        (phase_q == PH_IDLE && !burst_start) |=> rdy);

    // R3
    start_wait_chk: assert property (@(posedge clk) disable iff (rst)
        burst_start |=> !rdy);

    // R4
    addr_step_chk: assert property (@(posedge clk) disable iff (rst)
        xfer |=> (word_addr == $past(word_addr) + ADDR_W'(1)));

    // R5
    gap_one_chk: assert property (@(posedge clk) disable iff (rst)
        (xfer && grp_end && !wait2_cfg) |=> !rdy);

    // R6
    gap_two_chk: assert property (@(posedge clk) disable iff (rst)
        (two_gap_q && burst_adv && !burst_start) |=> !rdy);

    // R8
    restart_addr_chk: assert property (@(posedge clk) disable iff (rst)
        burst_start |=> (word_addr == $past(start_addr)));

    // R9
    end_burst_chk: assert property (@(posedge clk) disable iff (rst)
        (!burst_adv && !burst_start) |=> rdy);

endmodule

bind brrg_ready_gen brrg_ready_gen_chk #(
    .ADDR_W  (ADDR_W),
    .GROUP_W (GROUP_W)
) chk_i (
    .clk         (clk),
    .rst         (rst),
    .burst_start (burst_start),
    .start_addr  (start_addr),
    .burst_adv   (burst_adv),
    .wait2_cfg   (wait2_cfg),
    .rdy         (rdy),
    .phase_q     (phase_q),
    .word_addr   (word_addr)
);

// File: tb/brrg_ready_gen_tb_top.sv
module brrg_ready_gen_tb_top;

    localparam int AW  = 22;
    localparam int LAT = 4;
    localparam int GW  = 6;

    logic          clk = 1'b0;
    logic          rst;
    logic          burst_start;
    logic [AW-1:0] start_addr;
    logic          burst_adv;
    logic          wait2_cfg;
    logic          rdy;

    always #5 clk = ~clk;

    brrg_ready_gen #(.ADDR_W(AW), .LAT_CYC(LAT), .GROUP_W(GW)) dut_i (
        .clk         (clk),
        .rst         (rst),
        .burst_start (burst_start),
        .start_addr  (start_addr),
        .burst_adv   (burst_adv),
        .wait2_cfg   (wait2_cfg),
        .rdy         (rdy)
    );

    int n_chk = 0;
    int n_bad = 0;

    // Reference state, derived from the requirements
    bit            m_act = 1'b0;
    int            m_low = 0;
    logic [AW-1:0] m_addr = '0;
    int            m_bnd = 0;
    string         m_tag = "R1";

    function automatic bit last_in_group(input logic [AW-1:0] a);
        return a[GW-1:0] == {GW{1'b1}};
    endfunction

    function automatic bit want_rdy();
        return !m_act || (m_low == 0);
    endfunction

    task automatic check(input bit act, input bit exp, input string tag);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: rdy=%0b expected=%0b at %0t", tag, act, exp, $time);
        end
    endtask

    // One clock: drive at the falling edge, update model after the rising edge, check at the next falling edge
    task automatic cyc(input bit r, input bit s, input logic [AW-1:0] a, input bit v, input bit w);
        rst = r; burst_start = s; start_addr = a; burst_adv = v; wait2_cfg = w;
        @(posedge clk);
        if (r) begin
            m_act = 1'b0; m_low = 0; m_tag = "R1";
        end else if (s) begin
            m_tag  = m_act ? "R8" : "R3";
            m_act  = 1'b1; m_low = LAT; m_addr = a; m_bnd = 0;
        end else if (!m_act) begin
            m_tag = "R2";
        end else if (!v) begin
            m_act = 1'b0; m_low = 0; m_tag = "R9";
        end else if (m_low > 0) begin
            m_low--;
        end else begin
            if (last_in_group(m_addr)) begin
                m_low = w ? 2 : 1;
                m_tag = (m_bnd > 0) ? "R7" : (w ? "R6" : "R5");
                m_bnd++;
            end else begin
                m_tag = "R4";
            end
            m_addr = m_addr + AW'(1);
        end
        @(negedge clk);
        check(rdy, want_rdy(), m_tag);
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: run did not finish, rdy=%0b expected=finish", rdy);
        summary();
        $finish;
    end

    initial begin
        void'($urandom(32'd1357));
        rst = 1'b1; burst_start = 1'b0; start_addr = '0; burst_adv = 1'b0; wait2_cfg = 1'b0;
        @(negedge clk);

        // R1: reset state
        repeat (3) cyc(1, 0, '0, 0, 0);

        // R2: idle, other inputs wiggle
        for (int i = 0; i < 6; i++) cyc(0, 0, AW'($urandom), i[0], i[1]);

        // R3, R4, R5, R7: start just below a boundary, cross two boundaries
        cyc(0, 1, AW'(22'h00003C), 1, 0);
        for (int i = 0; i < LAT + 8; i++) cyc(0, 0, '0, 1, 0);
        for (int i = 0; i < 66; i++) cyc(0, 0, '0, 1, 1);

        // R6: first boundary with two-cycle wait
        cyc(0, 1, AW'(22'h00013F), 1, 1);
        for (int i = 0; i < LAT + 6; i++) cyc(0, 0, '0, 1, 1);

        // R8: restart while running, then again during latency
        cyc(0, 1, AW'(22'h00027E), 1, 0);
        cyc(0, 0, '0, 1, 0);
        cyc(0, 1, AW'(22'h0003BD), 1, 1);
        for (int i = 0; i < LAT + 6; i++) cyc(0, 0, '0, 1, 1);

        // R8: restart inside a boundary wait
        cyc(0, 1, AW'(22'h00043F), 1, 1);
        for (int i = 0; i < LAT + 1; i++) cyc(0, 0, '0, 1, 1);
        cyc(0, 1, AW'(22'h00053E), 1, 0);
        for (int i = 0; i < LAT + 4; i++) cyc(0, 0, '0, 1, 0);

        // R9: drop active, then active without a start stays idle (R2)
        cyc(0, 0, '0, 0, 0);
        cyc(0, 0, '0, 0, 1);
        for (int i = 0; i < 4; i++) cyc(0, 0, '0, 1, 0);

        // Constrained random mix
        for (int i = 0; i < 6000; i++) begin
            bit            r, s, v, w;
            logic [AW-1:0] a;
            r = ($urandom % 500) == 0;
            s = ($urandom % 40) == 0;
            v = ($urandom % 30) != 0;
            w = $urandom % 2;
            a = AW'($urandom);
            if ($urandom % 2) a[GW-1:0] = GW'({GW{1'b1}} - ($urandom % 4));
            cyc(r, s, a, v, w);
        end

        summary();
        $finish;
    end

endmodule